// File: doc/BRIEF.md
# Serial Increment/Decrement Wiper Stepper

This block runs the fine-tuning phase of a serial-bus digital potentiometer controller. An instruction executor decodes the increment/decrement opcode (0010 in the upper nibble of the instruction byte). Once it has acknowledged that byte, it pulses `mode_en`. It also presents the two-bit pot index that was taken from the low bits of the same byte. From then on the block owns the bus clock. Each SCL high pulse is one step command for the chosen wiper. Byte framing and acknowledge generation stay suspended while `mode_active` is high.

The bus front end supplies single-cycle pulses for the SCL rising edge, the SCL falling edge, START and STOP, all already synchronised, along with the synchronised SDA level. SDA is captured on each SCL rise. The step is issued on the SCL fall that follows. A START or STOP, which always happens while SCL is high, therefore cancels a pending step instead of causing one.

The block reads the current contents of all wiper registers and emits a one-cycle request that carries the pot index, the direction and the saturated new value. It asks only for volatile wiper updates and never requests a non-volatile program cycle.

Top module: `ser_wiper_stepper`

## Requirements
- R1: While reset is held, and in the first cycle after it, `mode_active` and `step_valid` are 0.
- R2: Stepping mode is entered only by a `mode_en` pulse. `mode_active` goes high in the cycle after the pulse, and `pot_sel` is captured in the pulse cycle. SCL pulses that arrive while the mode is inactive produce no request.
- R3: In the mode, the SDA level is sampled in the cycle flagged by `scl_rise`. If SDA was 1, then in the cycle after the next `scl_fall` the block raises `step_valid` with `step_up`=1 and `step_value` = selected wiper + 1. The wiper value used is the one presented in the `scl_fall` cycle.
- R4: If the sampled SDA level was 0, the request carries `step_up`=0 and `step_value` = selected wiper − 1.
- R5: Stepping saturates. An up step on a wiper at 255, or a down step on a wiper at 0, produces no request, so the position never wraps.
- R6: A `stop_det` or `start_det` pulse clears the mode in the next cycle and drops any step that was sampled on a rise but not yet issued. Later SCL pulses produce nothing until the next `mode_en`.
- R7: An `scl_fall` that has no sampled `scl_rise` before it in the current mode produces no request. This includes the first fall after entry. An `scl_rise` in the same cycle as `mode_en` is ignored.
- R8: A `mode_en` pulse while the mode is already active switches to the new `pot_sel` and drops any pending step.
- R9: Any number of steps, in any mix of directions, may follow in one mode. Each request lasts exactly one cycle, and `step_sel` equals the captured pot index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| scl_rise | input | 1 | One-cycle pulse on a synchronised SCL rising edge |
| scl_fall | input | 1 | One-cycle pulse on a synchronised SCL falling edge |
| sda_in | input | 1 | Synchronised SDA level |
| start_det | input | 1 | One-cycle pulse on a START or repeated START |
| stop_det | input | 1 | One-cycle pulse on a STOP |
| mode_en | input | 1 | Executor pulse after acknowledging the increment/decrement instruction |
| pot_sel | input | SEL_W (2) | Pot index from the instruction byte, captured with `mode_en` |
| wiper_cur | input | NUM_POTS*WIPER_W (32) | Current wiper registers, pot k in bits [k*WIPER_W +: WIPER_W] |
| mode_active | output | 1 | High while stepping mode owns the bus |
| step_valid | output | 1 | One-cycle wiper update request |
| step_up | output | 1 | Direction of the request, 1 = toward the high terminal |
| step_sel | output | SEL_W (2) | Pot whose wiper is updated |
| step_value | output | WIPER_W (8) | New saturated wiper value |

## Verification
The hardest cases to reach are the ones that depend on where a control pulse lands relative to the two SCL edges of a step. Examples are a STOP or repeated START between the sampling rise and the issuing fall, a `mode_en` in the same cycle as a rise or fall, and a re-entry that targets another pot while a step is pending. The bench drives each front-end pulse in a cycle it chooses, so it places these events exactly. It also preloads wipers one tap from each end so that saturation is hit after a few steps. A long run of mixed directions then shows that the model and the design stay in step over hundreds of requests.

// File: rtl/wstep_pkg.sv
`timescale 1ns/1ps
package wstep_pkg;

    typedef enum logic {
        MODE_OFF  = 1'b0,
        MODE_STEP = 1'b1
    } step_mode_e;

    typedef enum logic {
        DIR_DOWN = 1'b0,
        DIR_UP   = 1'b1
    } step_dir_e;

endpackage

// File: rtl/wstep_ctrl.sv
`timescale 1ns/1ps
module wstep_ctrl
    import wstep_pkg::*;
#(
    parameter int NUM_POTS = 4,
    localparam int SEL_W = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             scl_rise,
    input  logic             scl_fall,
    input  logic             sda_in,
    input  logic             start_det,
    input  logic             stop_det,
    input  logic             mode_en,
    input  logic [SEL_W-1:0] pot_sel,
    output logic             active,
    output logic             fire,
    output step_dir_e        fire_dir,
    output logic [SEL_W-1:0] sel
);

    typedef struct packed {
        step_mode_e       mode;
        logic             armed;
        step_dir_e        dir;
        logic [SEL_W-1:0] sel;
    } ctrl_t;

    ctrl_t ctrl_d, ctrl_q;
    logic  fire_d;

    // Priority: bus condition > entry > clock edges.
    always_comb begin
        ctrl_d = ctrl_q;
        fire_d = 1'b0;
        if (stop_det || start_det) begin
            ctrl_d.mode  = MODE_OFF;
            ctrl_d.armed = 1'b0;
        end else if (mode_en) begin
            ctrl_d.mode  = MODE_STEP;
            ctrl_d.armed = 1'b0;
            ctrl_d.sel   = pot_sel;
        end else if (ctrl_q.mode == MODE_STEP) begin
            if (scl_rise) begin
                ctrl_d.armed = 1'b1;
                ctrl_d.dir   = sda_in ? DIR_UP : DIR_DOWN;
            end else if (scl_fall && ctrl_q.armed) begin
                ctrl_d.armed = 1'b0;
                fire_d       = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{mode: MODE_OFF, armed: 1'b0, dir: DIR_DOWN, sel: '0};
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    assign active   = (ctrl_q.mode == MODE_STEP);
    assign fire     = fire_d;
    assign fire_dir = ctrl_q.dir;
    assign sel      = ctrl_q.sel;

endmodule

// File: rtl/wstep_sat.sv
`timescale 1ns/1ps
module wstep_sat
    import wstep_pkg::*;
#(
    parameter int NUM_POTS = 4,
    parameter int WIPER_W  = 8,
    localparam int SEL_W   = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1,
    localparam int FLAT_W  = NUM_POTS * WIPER_W
) (
    input  logic [FLAT_W-1:0]  wiper_flat,
    input  logic [SEL_W-1:0]   sel,
    input  step_dir_e          dir,
    output logic [WIPER_W-1:0] sel_val,
    output logic               blocked,
    output logic [WIPER_W-1:0] next_val
);

    logic [WIPER_W-1:0] slice [NUM_POTS];

    for (genvar g = 0; g < NUM_POTS; g++) begin : g_slice
        assign slice[g] = wiper_flat[g*WIPER_W +: WIPER_W];
    end

    logic at_top, at_bottom;

    always_comb begin
        sel_val   = slice[sel];
        at_top    = &sel_val;
        at_bottom = ~|sel_val;
        if (dir == DIR_UP) begin
            blocked  = at_top;
            next_val = sel_val + 1'b1;
        end else begin
            blocked  = at_bottom;
            next_val = sel_val - 1'b1;
        end
    end

endmodule

// File: rtl/ser_wiper_stepper.sv
`timescale 1ns/1ps
module ser_wiper_stepper
    import wstep_pkg::*;
#(
    parameter int NUM_POTS = 4,
    parameter int WIPER_W  = 8,
    localparam int SEL_W   = (NUM_POTS > 1) ? $clog2(NUM_POTS) : 1,
    localparam int FLAT_W  = NUM_POTS * WIPER_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               scl_rise,
    input  logic               scl_fall,
    input  logic               sda_in,
    input  logic               start_det,
    input  logic               stop_det,
    input  logic               mode_en,
    input  logic [SEL_W-1:0]   pot_sel,
    input  logic [FLAT_W-1:0]  wiper_cur,
    output logic               mode_active,
    output logic               step_valid,
    output logic               step_up,
    output logic [SEL_W-1:0]   step_sel,
    output logic [WIPER_W-1:0] step_value
);

    typedef struct packed {
        logic               valid;
        logic               up;
        logic [SEL_W-1:0]   sel;
        logic [WIPER_W-1:0] value;
    } req_t;

    logic               fire;
    step_dir_e          fire_dir;
    logic [SEL_W-1:0]   cur_sel;
    logic [WIPER_W-1:0] sel_val;
    logic               blocked;
    logic [WIPER_W-1:0] next_val;

    wstep_ctrl #(.NUM_POTS(NUM_POTS)) ctrl_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .sda_in    (sda_in),
        .start_det (start_det),
        .stop_det  (stop_det),
        .mode_en   (mode_en),
        .pot_sel   (pot_sel),
        .active    (mode_active),
        .fire      (fire),
        .fire_dir  (fire_dir),
        .sel       (cur_sel)
    );

    wstep_sat #(.NUM_POTS(NUM_POTS), .WIPER_W(WIPER_W)) sat_i (
        .wiper_flat (wiper_cur),
        .sel        (cur_sel),
        .dir        (fire_dir),
        .sel_val    (sel_val),
        .blocked    (blocked),
        .next_val   (next_val)
    );

    req_t req_d, req_q;

    always_comb begin
        req_d       = req_q;
        req_d.valid = fire && !blocked;
        if (fire && !blocked) begin
            req_d.up    = (fire_dir == DIR_UP);
            req_d.sel   = cur_sel;
            req_d.value = next_val;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            req_q <= '0;
        end else begin
            req_q <= req_d;
        end
    end

    assign step_valid = req_q.valid;
    assign step_up    = req_q.up;
    assign step_sel   = req_q.sel;
    assign step_value = req_q.value;

endmodule

// File: rtl/wstep_chk.sv
`timescale 1ns/1ps
module wstep_chk #(
    parameter int WIPER_W = 8
) (
    input logic               clk,
    input logic               rst_n,
    input logic               start_det,
    input logic               stop_det,
    input logic               mode_en,
    input logic               mode_active,
    input logic               step_valid,
    input logic               step_up,
    input logic [WIPER_W-1:0] step_value,
    input logic [WIPER_W-1:0] sel_val
);

    // R2
    enter_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_en && !stop_det && !start_det) |=> mode_active);

    // R2
    req_needs_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> $past(mode_active));

    // R3
    inc_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && step_up) |-> (step_value == WIPER_W'($past(sel_val) + 1'b1)));

    // R4
    dec_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (step_valid && !step_up) |-> (step_value == WIPER_W'($past(sel_val) - 1'b1)));

    // R5
    no_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |-> (step_up ? (step_value != '0) : (step_value != '1)));

    // R6
    bus_cond_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_det || start_det) |=> (!step_valid && !mode_active));

    // R9
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        step_valid |=> !step_valid);

endmodule

bind ser_wiper_stepper wstep_chk #(.WIPER_W(WIPER_W)) chk_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_det   (start_det),
    .stop_det    (stop_det),
    .mode_en     (mode_en),
    .mode_active (mode_active),
    .step_valid  (step_valid),
    .step_up     (step_up),
    .step_value  (step_value),
    .sel_val     (sel_val)
);

// File: tb/ser_wiper_stepper_tb_top.sv
`timescale 1ns/1ps
module ser_wiper_stepper_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scl_rise = 1'b0, scl_fall = 1'b0, sda_in = 1'b0;
    logic        start_det = 1'b0, stop_det = 1'b0, mode_en = 1'b0;
    logic [1:0]  pot_sel = 2'd0;
    logic [31:0] wiper_cur;
    logic        mode_active, step_valid, step_up;
    logic [1:0]  step_sel;
    logic [7:0]  step_value;

    int wip [4] = '{0, 0, 0, 0};
    assign wiper_cur = {wip[3][7:0], wip[2][7:0], wip[1][7:0], wip[0][7:0]};

    always #2.5 clk = ~clk;

    ser_wiper_stepper dut_i (
        .clk(clk), .rst_n(rst_n), .scl_rise(scl_rise), .scl_fall(scl_fall),
        .sda_in(sda_in), .start_det(start_det), .stop_det(stop_det),
        .mode_en(mode_en), .pot_sel(pot_sel), .wiper_cur(wiper_cur),
        .mode_active(mode_active), .step_valid(step_valid), .step_up(step_up),
        .step_sel(step_sel), .step_value(step_value)
    );

    int    n_checks = 0;
    int    n_fails  = 0;
    int    cycles   = 0;
    bit    done     = 0;
    string cur_req  = "R1";

    // Behavioural reference state
    bit m_active = 0, m_armed = 0, m_dir = 0;
    int m_sel = 0;
    bit exp_valid = 0, exp_up = 0, exp_active = 0;
    int exp_sel = 0, exp_value = 0;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (!rst_n) begin
            m_active = 0; m_armed = 0; m_dir = 0; m_sel = 0;
            exp_valid = 0; exp_active = 0;
        end else begin
            bit nv;
            int w;
            nv = 0;
            if (exp_valid) wip[exp_sel] <= exp_value;  // external register takes the request
            if (stop_det || start_det) begin
                m_active = 0; m_armed = 0;
            end else if (mode_en) begin
                m_active = 1; m_armed = 0; m_sel = int'(pot_sel);
            end else if (m_active) begin
                if (scl_rise) begin
                    m_armed = 1; m_dir = sda_in;
                end else if (scl_fall && m_armed) begin
                    m_armed = 0;
                    w = wip[m_sel];
                    if (m_dir && w < 255) begin
                        nv = 1; exp_value = w + 1;
                    end else if (!m_dir && w > 0) begin
                        nv = 1; exp_value = w - 1;
                    end
                    if (nv) begin
                        exp_up = m_dir; exp_sel = m_sel;
                    end
                end
            end
            exp_valid  = nv;
            exp_active = m_active;
        end
    end

    // Compare every clock, away from the active edge
    always @(negedge clk) begin
        if (!done) begin
            bit bad;
            n_checks++;
            bad = (step_valid !== exp_valid) || (mode_active !== exp_active);
            if (exp_valid && (step_up !== exp_up || int'(step_sel) != exp_sel ||
                              int'(step_value) != exp_value)) bad = 1;
            if (bad) begin
                n_fails++;
                $display("FAIL %s t=%0t: actual valid=%0b active=%0b up=%0b sel=%0d val=%0d expected valid=%0b active=%0b up=%0b sel=%0d val=%0d",
                         cur_req, $time, step_valid, mode_active, step_up, step_sel, step_value,
                         exp_valid, exp_active, exp_up, exp_sel, exp_value);
            end
        end
    end

    always @(posedge clk) begin
        if (cycles > 150000 && !done) begin
            done = 1;
            n_fails++;
            $display("FAIL watchdog (R1..all): actual cycles=%0d expected below 150000", cycles);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
            $finish;
        end
    end

    task automatic drive(input bit r, input bit f, input bit st, input bit sp,
                         input bit me, input int ps);
        @(negedge clk);
        scl_rise = r; scl_fall = f; start_det = st; stop_det = sp;
        mode_en = me; pot_sel = ps[1:0];
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) drive(0, 0, 0, 0, 0, 0);
    endtask

    task automatic enter(input int p);
        drive(0, 0, 0, 0, 1, p);
        idle(1);
    endtask

    task automatic step(input bit up);
        @(negedge clk); sda_in = up;
        drive(1, 0, 0, 0, 0, 0);
        idle(1);
        drive(0, 1, 0, 0, 0, 0);
        idle(2);
    endtask

    task automatic stop_bus();
        drive(0, 0, 0, 1, 0, 0);
        idle(2);
    endtask

    task automatic set_wiper(input int p, input int v);
        @(negedge clk); wip[p] = v;
    endtask

    task automatic check_int(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    initial begin
        int lfsr;
        // R1: reset state, compared on every clock during and after reset
        cur_req = "R1";
        idle(4);
        rst_n = 1'b1;
        idle(2);

        // R2: clock pulses before any mode_en are ignored
        cur_req = "R2";
        set_wiper(0, 10); set_wiper(1, 100); set_wiper(2, 254); set_wiper(3, 1);
        step(1); step(0); step(1);
        check_int("R2", wip[0], 10);

        // R3 / R4: up and down steps on pot 1
        cur_req = "R3";
        enter(1);
        step(1); step(1); step(1);
        check_int("R3", wip[1], 103);
        cur_req = "R4";
        step(0); step(0);
        check_int("R4", wip[1], 101);
        stop_bus();

        // R5: saturation at both ends
        cur_req = "R5";
        enter(2);
        step(1); step(1); step(1);
        check_int("R5 top", wip[2], 255);
        stop_bus();
        enter(3);
        step(0); step(0); step(0);
        check_int("R5 bottom", wip[3], 0);
        step(1);
        check_int("R5 recover", wip[3], 1);
        stop_bus();

        // R6: STOP between rise and fall cancels the sampled step
        cur_req = "R6";
        enter(0);
        @(negedge clk); sda_in = 1;
        drive(1, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 1, 0, 0);
        drive(0, 1, 0, 0, 0, 0);
        idle(2);
        step(1);
        check_int("R6 stop", wip[0], 10);
        // R6: repeated START likewise
        enter(0);
        @(negedge clk); sda_in = 0;
        drive(1, 0, 0, 0, 0, 0);
        drive(0, 0, 1, 0, 0, 0);
        drive(0, 1, 0, 0, 0, 0);
        idle(2);
        check_int("R6 start", wip[0], 10);

        // R7: fall with no prior rise, rise in the entry cycle
        cur_req = "R7";
        drive(1, 0, 0, 0, 1, 0);
        drive(0, 1, 0, 0, 0, 0);
        idle(2);
        drive(0, 1, 0, 0, 0, 0);
        idle(2);
        check_int("R7", wip[0], 10);

        // R8: re-entry switches pot and drops the pending step
        cur_req = "R8";
        @(negedge clk); sda_in = 1;
        drive(1, 0, 0, 0, 0, 0);
        drive(0, 0, 0, 0, 1, 1);
        drive(0, 1, 0, 0, 0, 0);
        idle(2);
        check_int("R8 dropped", wip[0], 10);
        step(1);
        check_int("R8 new pot", wip[1], 102);
        stop_bus();

        // R9: long mixed burst in one transaction
        cur_req = "R9";
        set_wiper(2, 128);
        enter(2);
        lfsr = 32'h1d3a;
        for (int i = 0; i < 400; i++) begin
            lfsr = (lfsr >> 1) ^ ((lfsr & 1) ? 32'hb400 : 0);
            step(lfsr[0] | (i < 150 && lfsr[1]));
        end
        stop_bus();
        idle(4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
        $finish;
    end

endmodule